// File: doc/BRIEF.md
# Strap-latched frequency mode selector

This block decides, once per power cycle, which operating mode a clock generator runs in. It watches an active-low power-good input through a synchronizer. The first clock on which that input is seen low, it latches two frequency-select straps. The first strap is a plain two-level signal. The second strap can be low, high or mid, and arrives as a 2-bit level code. After that single capture the straps and the power-good input no longer affect anything, so the chosen CPU frequency stays fixed for the rest of the power cycle.

If the second strap was at mid level when capture happened, the block enters a sticky test-clock mode. In this mode the first strap steers the outputs live and without a clock, choosing between all outputs at high impedance and all outputs at the reference divided down. A separate register bit selects an alternate, higher CPU frequency table. The latched strap values are presented as a readback byte.

The result is a mode code that every clock domain shares, plus the selected CPU frequency in MHz. The other domains run at fixed rates in run mode: 66 MHz, 33 MHz, 48 MHz and 14.318 MHz.

Top module: `strap_mode_sel`

## Requirements
- R1: While reset is high and after it is released, until capture happens, the outputs are held as follows: `out_mode` is IDLE (2'b00), `cpu_mhz` is 0, `strap_rb` is 0, and `locked` and `test_active` are 0.
- R2: `pwrgd_n` passes through SYNC_STAGES flops. Capture happens on the (SYNC_STAGES+1)-th rising edge after `pwrgd_n` goes low, and not before that edge.
- R3: Once `locked` is 1, changes on `pwrgd_n`, `fs_a` and `fs_b` leave `locked`, `strap_rb` and, outside test mode, `out_mode` and `cpu_mhz` unchanged.
- R4: The `fs_b` level code is 00 for low, 01 for high, 10 for mid and 11 for mid as well. When capture happens with `fs_b` low or high and `alt_sel`=0, `out_mode` is RUN (2'b01). `cpu_mhz` is then set by {fs_a, fs_b-high} as follows: 00 gives 100, 01 gives 200, 10 gives 133 and 11 gives 166.
- R5: In run mode with `alt_sel`=1, `cpu_mhz` follows the alternate table: 00 gives 200, 01 gives 400, 10 gives 266 and 11 gives 333. `alt_sel` acts combinationally at any time after capture.
- R6: A capture with `fs_b` at mid (10 or 11) sets `test_active`=1 and `locked`=1. `test_active` then stays 1 until reset.
- R7: In test mode, `out_mode` follows the live `fs_a` without a clock: `fs_a`=0 gives REFN (2'b11) and `fs_a`=1 gives HIZ (2'b10). `cpu_mhz` stays 0, and `fs_b` and `alt_sel` have no effect.
- R8: `strap_rb` bit 0 holds the captured `fs_a`. Bit 1 is 1 only when the captured `fs_b` was high. Bits 7:2 read 0.
- R9: Reset clears test mode. A later capture with `fs_b` low or high gives normal run-mode decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models a power cycle |
| pwrgd_n | input | 1 | Asynchronous active-low power-good |
| fs_a | input | 1 | Two-level frequency strap |
| fs_b | input | 2 | Three-level strap code: 00 low, 01 high, 10/11 mid |
| alt_sel | input | 1 | Register bit selecting the alternate CPU table |
| out_mode | output | 2 | Shared mode code: 00 IDLE, 01 RUN, 10 HIZ, 11 REFN |
| cpu_mhz | output | 9 | Selected CPU frequency in MHz, 0 unless RUN |
| strap_rb | output | RB_W | Readback byte of the latched straps |
| locked | output | 1 | Straps have been captured |
| test_active | output | 1 | Test-clock mode is active |

## Verification
The bench builds the block with SYNC_STAGES=2 and RB_W=8. It derives the capture edge from SYNC_STAGES, so it can check the cycle before capture as well as the capture cycle itself. With these values all eight normal and alternate table entries can be reached, each after a fresh reset. Both mid codes are reached too, along with the live steering of test mode and the return to run mode after a reset.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;

    localparam int MHZ_W = 9;

    // Fixed-domain rates in run mode, in kHz, kept here for system users.
    localparam int unsigned MID_BUS_KHZ = 66_000;
    localparam int unsigned IO_BUS_KHZ  = 33_000;
    localparam int unsigned SERIAL_KHZ  = 48_000;
    localparam int unsigned REF_KHZ     = 14_318;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RUN  = 2'b01,
        MODE_HIZ  = 2'b10,
        MODE_REFN = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID  = 2'b10,
        LVL_MID2 = 2'b11
    } strap_lvl_e;

    typedef struct packed {
        logic locked;
        logic test;
        logic sa;
        logic sb_high;
    } strap_state_t;

    function automatic logic lvl_is_mid(input logic [1:0] lvl);
        return lvl[1];
    endfunction

    function automatic logic [MHZ_W-1:0] cpu_rate(input logic alt,
                                                  input logic sa,
                                                  input logic sb);
        logic [MHZ_W-1:0] r;
        case ({alt, sa, sb})
            3'b000:  r = MHZ_W'(100);
            3'b001:  r = MHZ_W'(200);
            3'b010:  r = MHZ_W'(133);
            3'b011:  r = MHZ_W'(166);
            3'b100:  r = MHZ_W'(200);
            3'b101:  r = MHZ_W'(400);
            3'b110:  r = MHZ_W'(266);
            default: r = MHZ_W'(333);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_n};
        end
    end

    assign q_n = chain[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_sel_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pg_low,
    input  logic         fs_a,
    input  logic [1:0]   fs_b,
    output strap_state_t st
);
    strap_state_t nxt;

    always_comb begin
        nxt = st;
        if (!st.locked && pg_low) begin
            nxt.locked  = 1'b1;
            nxt.test    = lvl_is_mid(fs_b);
            nxt.sa      = fs_a;
            nxt.sb_high = (fs_b == LVL_HIGH);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import strap_sel_pkg::*;
(
    input  strap_state_t     st,
    input  logic             fs_a_live,
    input  logic             alt_sel,
    output clk_mode_e        mode,
    output logic [MHZ_W-1:0] mhz
);
    always_comb begin
        mode = MODE_IDLE;
        mhz  = '0;
        if (st.locked) begin
            if (st.test) begin
                mode = fs_a_live ? MODE_HIZ : MODE_REFN;
            end else begin
                mode = MODE_RUN;
                mhz  = cpu_rate(alt_sel, st.sa, st.sb_high);
            end
        end
    end
endmodule

// File: rtl/strap_readback.sv
module strap_readback
    import strap_sel_pkg::*;
#(
    parameter int RB_W  = 8,
    parameter int A_POS = 0,
    parameter int B_POS = 1
) (
    input  strap_state_t    st,
    output logic [RB_W-1:0] rb
);
    for (genvar i = 0; i < RB_W; i++) begin : g_bit
        if (i == A_POS) begin : g_a
            assign rb[i] = st.sa;
        end else if (i == B_POS) begin : g_b
            assign rb[i] = st.sb_high;
        end else begin : g_z
            assign rb[i] = 1'b0;
        end
    end
endmodule

// File: rtl/strap_mode_sel.sv
module strap_mode_sel
    import strap_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RB_W        = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pwrgd_n,
    input  logic                      fs_a,
    input  logic [1:0]                fs_b,
    input  logic                      alt_sel,
    output logic [1:0]                out_mode,
    output logic [strap_sel_pkg::MHZ_W-1:0] cpu_mhz,
    output logic [RB_W-1:0]           strap_rb,
    output logic                      locked,
    output logic                      test_active
);
    logic         pg_sync_n;
    logic         pg_low;
    strap_state_t st;
    clk_mode_e    mode;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (pwrgd_n),
        .q_n (pg_sync_n)
    );

    assign pg_low = ~pg_sync_n;

    strap_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .pg_low (pg_low),
        .fs_a   (fs_a),
        .fs_b   (fs_b),
        .st     (st)
    );

    mode_decode u_dec (
        .st        (st),
        .fs_a_live (fs_a),
        .alt_sel   (alt_sel),
        .mode      (mode),
        .mhz       (cpu_mhz)
    );

    strap_readback #(.RB_W(RB_W), .A_POS(0), .B_POS(1)) u_rb (
        .st (st),
        .rb (strap_rb)
    );

    assign out_mode    = mode;
    assign locked      = st.locked;
    assign test_active = st.test;
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk
    import strap_sel_pkg::*;
#(
    parameter int RB_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pg_low,
    input logic             fs_a,
    input logic [1:0]       out_mode,
    input logic [MHZ_W-1:0] cpu_mhz,
    input logic [RB_W-1:0]  strap_rb,
    input logic             locked,
    input logic             test_active
);
    assert_idle_before_lock_R1: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (out_mode == MODE_IDLE && cpu_mhz == '0 && strap_rb == '0));

    assert_capture_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (!locked && pg_low) |=> locked);

    assert_no_early_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!locked && !pg_low) |=> !locked);

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    assert_rb_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(strap_rb));

    assert_run_rate_R4: assert property (@(posedge clk) disable iff (rst)
        (locked && !test_active) |-> (out_mode == MODE_RUN && cpu_mhz != '0));

    assert_test_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        test_active |=> test_active);

    assert_test_steer_R7: assert property (@(posedge clk) disable iff (rst)
        test_active |-> (out_mode == (fs_a ? MODE_HIZ : MODE_REFN) && cpu_mhz == '0));
endmodule

bind strap_mode_sel strap_mode_chk #(.RB_W(RB_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pg_low      (pg_low),
    .fs_a        (fs_a),
    .out_mode    (out_mode),
    .cpu_mhz     (cpu_mhz),
    .strap_rb    (strap_rb),
    .locked      (locked),
    .test_active (test_active)
);

// File: tb/tb_strap_mode_sel.sv
module tb_strap_mode_sel;
    localparam int SYNC = 2;
    localparam int RBW  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic       fs_a = 1'b0;
    logic [1:0] fs_b = 2'b00;
    logic       alt_sel = 1'b0;
    logic [1:0] out_mode;
    logic [8:0] cpu_mhz;
    logic [RBW-1:0] strap_rb;
    logic       locked;
    logic       test_active;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [1:0] mode;
        logic [8:0] mhz;
        logic [7:0] rb;
        logic       lk;
        logic       tm;
    } exp_t;

    exp_t q[$];
    event chk_ev;

    always #4 clk = ~clk;

    strap_mode_sel #(.SYNC_STAGES(SYNC), .RB_W(RBW)) dut (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .fs_a(fs_a), .fs_b(fs_b),
        .alt_sel(alt_sel), .out_mode(out_mode), .cpu_mhz(cpu_mhz),
        .strap_rb(strap_rb), .locked(locked), .test_active(test_active)
    );

    function automatic logic [8:0] table_mhz(input logic alt, input logic a, input logic b);
        logic [8:0] n [4] = '{9'd100, 9'd200, 9'd133, 9'd166};
        logic [8:0] x [4] = '{9'd200, 9'd400, 9'd266, 9'd333};
        return alt ? x[{a, b}] : n[{a, b}];
    endfunction

    task automatic expect_now(input string tag, input logic [1:0] m, input logic [8:0] f,
                              input logic [7:0] rb, input logic lk, input logic tm);
        exp_t e;
        e.tag = tag; e.mode = m; e.mhz = f; e.rb = rb; e.lk = lk; e.tm = tm;
        q.push_back(e);
        ->chk_ev;
        #2;
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_mode !== e.mode || cpu_mhz !== e.mhz || strap_rb !== e.rb ||
                    locked !== e.lk || test_active !== e.tm) begin
                    failures++;
                    $display("FAIL %s: got mode=%b mhz=%0d rb=%h lk=%b tm=%b exp mode=%b mhz=%0d rb=%h lk=%b tm=%b",
                             e.tag, out_mode, cpu_mhz, strap_rb, locked, test_active,
                             e.mode, e.mhz, e.rb, e.lk, e.tm);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        pwrgd_n = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic capture();
        pwrgd_n = 1'b0;
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_now("R1 during reset", 2'b00, 9'd0, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 after release", 2'b00, 9'd0, 8'h00, 1'b0, 1'b0);

        // R2 latency: one edge short still idle
        fs_a = 1'b1; fs_b = 2'b01; alt_sel = 1'b0;
        pwrgd_n = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        expect_now("R2 not yet captured", 2'b00, 9'd0, 8'h00, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect_now("R2/R4 capture edge", 2'b01, 9'd166, 8'h03, 1'b1, 1'b0);

        // R3 later changes ignored
        fs_a = 1'b0; fs_b = 2'b10; pwrgd_n = 1'b1;
        repeat (4) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (5) @(negedge clk);
        expect_now("R3 straps ignored", 2'b01, 9'd166, 8'h03, 1'b1, 1'b0);

        // R5 live alternate table
        alt_sel = 1'b1;
        expect_now("R5 alt live", 2'b01, 9'd333, 8'h03, 1'b1, 1'b0);
        @(negedge clk);
        alt_sel = 1'b0;
        expect_now("R5 alt back", 2'b01, 9'd166, 8'h03, 1'b1, 1'b0);

        // R4/R5/R8 every table entry
        for (int k = 0; k < 4; k++) begin
            do_reset();
            fs_a = k[1]; fs_b = k[0] ? 2'b01 : 2'b00; alt_sel = 1'b0;
            capture();
            expect_now("R4/R8 normal entry", 2'b01, table_mhz(1'b0, k[1], k[0]),
                       {6'b0, k[0], k[1]}, 1'b1, 1'b0);
            @(negedge clk);
            alt_sel = 1'b1;
            expect_now("R5 alt entry", 2'b01, table_mhz(1'b1, k[1], k[0]),
                       {6'b0, k[0], k[1]}, 1'b1, 1'b0);
        end

        // R6/R7 test mode via mid code 10
        do_reset();
        alt_sel = 1'b0; fs_a = 1'b0; fs_b = 2'b10;
        capture();
        expect_now("R6 mid enters test", 2'b11, 9'd0, 8'h00, 1'b1, 1'b1);
        fs_a = 1'b1;
        expect_now("R7 fs_a steers HIZ", 2'b10, 9'd0, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        fs_b = 2'b01; alt_sel = 1'b1; pwrgd_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_now("R7 fs_b/alt ignored", 2'b10, 9'd0, 8'h00, 1'b1, 1'b1);
        fs_a = 1'b0;
        expect_now("R7 fs_a steers REFN", 2'b11, 9'd0, 8'h00, 1'b1, 1'b1);

        // R6 mid code 11, readback bit0 holds captured fs_a (R8)
        do_reset();
        alt_sel = 1'b0; fs_a = 1'b1; fs_b = 2'b11;
        capture();
        expect_now("R6/R8 mid code 11", 2'b10, 9'd0, 8'h01, 1'b1, 1'b1);

        // R9 reset leaves test mode
        do_reset();
        expect_now("R9 reset clears test", 2'b00, 9'd0, 8'h00, 1'b0, 1'b0);
        fs_a = 1'b1; fs_b = 2'b00;
        capture();
        expect_now("R9 normal after test", 2'b01, 9'd133, 8'h01, 1'b1, 1'b0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule